// File: doc/BRIEF.md
# Filtered Event Counter Group

This block is a bank of programmable event counters that watches a translation unit. Each cycle the unit presents a few event lanes. Each lane carries a valid strobe, a 16-bit event code and the stream identifier of the traffic that caused the event. Every counter is programmed with one event code and a stream identifier filter. It adds the number of lanes that carry its code and pass its filter in that cycle.

Software controls the bank over a simple 32-bit register bus with byte addresses. Reads return data one cycle after the read strobe. Counter enables, interrupt enables and overflow status are each reached through a pair of set and clear registers, and both registers of a pair read back the current mask. Counters can be written at any time, so software can preload a value before it enables counting. When a counter wraps, its overflow bit is set. A registered level interrupt reports overflows that software has unmasked.

The filter has two modes. An exact mode compares the whole stream identifier. A span mode ignores every bit up to and including the lowest zero bit of the match value. A build-time option makes the filter of counter 0 govern every counter.

Top module: `evt_counter_group`

## Requirements
- R1: After reset, all counters, enable masks, overflow bits, the run and interrupt controls and `irq` are 0. Every event selector reads 0x2000_0000 (code 0, span set) and every match register reads all ones.
- R2: The register at 0xE00 is read-only. Bits [5:0] hold NUM_CTR-1, bits [13:8] hold CTR_W-1 and bit 23 is set when the filter is global. The supported-event mask EV_SUPPORT reads at 0xE20 (bits 31:0), 0xE24, 0xE28 and 0xE2C (bits 127:96).
- R3: A counter advances only while the run bit (0xE04 bit 0) and its enable bit are both 1. It then adds, in one cycle, the number of valid lanes whose code equals its selected code and whose identifier passes its filter.
- R4: The masks use bit n for counter n, with the low word at the listed address and the high word at +4. Counter enable is set at 0xC00 and cleared at 0xC20. Interrupt enable is set at 0xC40 and cleared at 0xC60. Overflow is cleared at 0xC80 and set at 0xCC0. Writing 1 to a bit changes only that bit, bits at or above NUM_CTR are ignored, and both registers of a pair read the current mask.
- R5: Counter n is writable. It sits at 4n when CTR_W is 32 or less. Otherwise it sits at 8n, with bits [CTR_W-1:32] at 8n+4. A write in the same cycle as a matching event stores the written value.
- R6: The event selector for counter n is at 0x400+4n, with the code in bits [15:0] and the span flag in bit 29. All other bits read 0.
- R7: With span 0, a lane passes only if its identifier equals the match register (0xA00+4n).
- R8: With span 1, the bits of the identifier at and below the lowest zero bit of the match value are ignored (0x45 accepts 0x44..0x47). A match value of all ones accepts every identifier.
- R9: When GLOBAL_FILT is 1, every counter uses the span flag and match register of counter 0, together with its own event code.
- R10: A wrap from all ones to zero sets the counter's overflow bit. When the wrap and an overflow-clear write for that bit fall in the same cycle, the bit ends up set.
- R11: `irq` is registered. One cycle after the interrupt control (0xE50 bit 0) is 1 and any counter has both its overflow bit and its interrupt enable bit set, `irq` is 1; otherwise it is 0.
- R12: Reads of unmapped or unaligned addresses return 0. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| ev_valid | input | LANES | Per-lane event strobe |
| ev_id | input | LANES*16 | Per-lane event code, lane 0 in the low bits |
| ev_sid | input | LANES*SID_W | Per-lane stream identifier, lane 0 in the low bits |
| irq | output | 1 | Level interrupt |

## Verification
The assertions take the event lanes and bus inputs to be known values on every clock edge. They also take a counter write to mean that the counter is loaded, not advanced. The filter checks rely on the match register and span flag being stable during the cycle in which they are compared. The directed stimulus drives every input at the falling edge and returns it to idle before the next operation. It never issues a read and a write in the same cycle and uses only word-aligned addresses, except in the test that covers unaligned access on purpose. Before each scenario it resets both bench instances, so state left by one task cannot reach the next.

// File: rtl/ecg_pkg.sv
`timescale 1ns/1ps
package ecg_pkg;
  localparam int EVID_W   = 16;
  localparam int SPAN_POS = 29;

  localparam logic [11:0] A_SEL     = 12'h400;
  localparam logic [11:0] A_MATCH   = 12'hA00;
  localparam logic [11:0] A_CEN_SET = 12'hC00;
  localparam logic [11:0] A_CEN_CLR = 12'hC20;
  localparam logic [11:0] A_IEN_SET = 12'hC40;
  localparam logic [11:0] A_IEN_CLR = 12'hC60;
  localparam logic [11:0] A_OVF_CLR = 12'hC80;
  localparam logic [11:0] A_OVF_SET = 12'hCC0;
  localparam logic [11:0] A_CFG     = 12'hE00;
  localparam logic [11:0] A_EVM_LO  = 12'hE20;
  localparam logic [11:0] A_EVM_HI  = 12'hE28;
  localparam logic [11:0] A_IRQCTL  = 12'hE50;

  typedef struct packed {
    logic              span;
    logic [EVID_W-1:0] code;
  } evsel_t;

  function automatic logic [31:0] half_of(input logic [63:0] v, input logic upper);
    return upper ? v[63:32] : v[31:0];
  endfunction
endpackage

// File: rtl/ecg_sid_filter.sv
`timescale 1ns/1ps
module ecg_sid_filter #(
  parameter int SID_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             span,
  input  logic [SID_W-1:0] match,
  input  logic [SID_W-1:0] sid,
  output logic             pass
);
  logic [SID_W-1:0] care;

  // In span mode the bits up to the lowest zero of match are don't-care.
  always_comb begin
    care = span ? ~(match ^ (match + SID_W'(1))) : '1;
    pass = ((sid ^ match) & care) == '0;
  end

  // R7
  exact_only_chk: assert property (@(posedge clk) disable iff (rst)
    (!span && pass) |-> (sid == match));

  // R8
  all_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (span && (&match)) |-> pass);
endmodule

// File: rtl/ecg_counter.sv
`timescale 1ns/1ps
module ecg_counter #(
  parameter int CTR_W = 32,
  parameter int SID_W = 32,
  parameter int LANES = 2
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               run,
  input  logic [LANES-1:0]                   ev_valid,
  input  logic [LANES*ecg_pkg::EVID_W-1:0]   ev_id,
  input  logic [LANES*SID_W-1:0]             ev_sid,
  input  ecg_pkg::evsel_t                    sel,
  input  logic [SID_W-1:0]                   match,
  input  logic                               wr_lo,
  input  logic                               wr_hi,
  input  logic [31:0]                        wdata,
  output logic [CTR_W-1:0]                   count,
  output logic                               wrap
);
  localparam int IDW   = ecg_pkg::EVID_W;
  localparam int INC_W = $clog2(LANES + 1);

  logic [LANES-1:0] pass, hit;
  logic [INC_W-1:0] inc;
  logic [CTR_W:0]   sum;
  logic [CTR_W-1:0] load_val;
  logic             loading;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    ecg_sid_filter #(.SID_W(SID_W)) u_filt (
      .clk   (clk),
      .rst   (rst),
      .span  (sel.span),
      .match (match),
      .sid   (ev_sid[l*SID_W +: SID_W]),
      .pass  (pass[l])
    );
    assign hit[l] = ev_valid[l] && (ev_id[l*IDW +: IDW] == sel.code) && pass[l];
  end

  always_comb begin
    inc = '0;
    for (int l = 0; l < LANES; l++) inc = inc + INC_W'(hit[l]);
    sum = {1'b0, count} + (CTR_W+1)'(inc);
  end

  if (CTR_W > 32) begin : g_wide
    always_comb load_val = wr_hi ? {wdata[CTR_W-33:0], count[31:0]}
                                 : {count[CTR_W-1:32], wdata};
  end else begin : g_narrow
    always_comb load_val = wdata[CTR_W-1:0];
  end

  assign loading = wr_lo || wr_hi;
  assign wrap    = run && !loading && sum[CTR_W];

  always_ff @(posedge clk) begin
    if (rst)          count <= '0;
    else if (loading) count <= load_val;
    else if (run)     count <= sum[CTR_W-1:0];
  end

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !loading) |=> $stable(count));

  // R3
  step_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (!loading) |=> (CTR_W'(count - $past(count)) <= CTR_W'(LANES)));
endmodule

// File: rtl/evt_counter_group.sv
`timescale 1ns/1ps
module evt_counter_group #(
  parameter int           NUM_CTR     = 4,
  parameter int           CTR_W       = 32,
  parameter int           SID_W       = 32,
  parameter int           LANES       = 2,
  parameter bit           GLOBAL_FILT = 1'b0,
  parameter logic [127:0] EV_SUPPORT  = 128'hFF
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             bus_wr,
  input  logic                             bus_rd,
  input  logic [11:0]                      bus_addr,
  input  logic [31:0]                      bus_wdata,
  output logic [31:0]                      bus_rdata,
  input  logic [LANES-1:0]                 ev_valid,
  input  logic [LANES*ecg_pkg::EVID_W-1:0] ev_id,
  input  logic [LANES*SID_W-1:0]           ev_sid,
  output logic                             irq
);
  import ecg_pkg::*;

  localparam bit WIDE     = (CTR_W > 32);
  localparam int SH       = WIDE ? 3 : 2;
  localparam int CTR_SPAN = NUM_CTR << SH;
  localparam logic [31:0] CFG_VAL = 32'(NUM_CTR - 1) | (32'(CTR_W - 1) << 8)
                                  | (32'(GLOBAL_FILT) << 23);

  // ---------------- address decode ----------------
  logic        aligned, upper;
  logic [11:0] pair;
  logic [5:0]  ctr_idx, reg_idx;
  logic        ctr_hit, sel_hit, mat_hit;
  logic [NUM_CTR-1:0] wmask;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign upper   = bus_addr[2];
  assign pair    = {bus_addr[11:3], 3'b000};
  assign ctr_idx = 6'(bus_addr >> SH);
  assign reg_idx = bus_addr[7:2];
  assign ctr_hit = aligned && (bus_addr < 12'(CTR_SPAN));
  assign sel_hit = aligned && (bus_addr[11:8] == A_SEL[11:8])   && (32'(reg_idx) < NUM_CTR);
  assign mat_hit = aligned && (bus_addr[11:8] == A_MATCH[11:8]) && (32'(reg_idx) < NUM_CTR);
  assign wmask   = NUM_CTR'(upper ? {bus_wdata, 32'h0} : {32'h0, bus_wdata});

  function automatic logic wr_at(input logic [11:0] base);
    return bus_wr && aligned && (pair == base);
  endfunction

  // ---------------- state ----------------
  logic [NUM_CTR-1:0] cen, ien, ovf, wrap;
  logic               run_en, irq_en;
  evsel_t             sel_q   [NUM_CTR];
  logic [SID_W-1:0]   match_q [NUM_CTR];
  logic [CTR_W-1:0]   cnt     [NUM_CTR];

  always_ff @(posedge clk) begin
    if (rst) begin
      cen    <= '0;
      ien    <= '0;
      ovf    <= '0;
      run_en <= 1'b0;
      irq_en <= 1'b0;
      irq    <= 1'b0;
      for (int n = 0; n < NUM_CTR; n++) begin
        sel_q[n]   <= '{span: 1'b1, code: '0};
        match_q[n] <= '1;
      end
    end else begin
      cen <= (cen | (wr_at(A_CEN_SET) ? wmask : '0)) & ~(wr_at(A_CEN_CLR) ? wmask : '0);
      ien <= (ien | (wr_at(A_IEN_SET) ? wmask : '0)) & ~(wr_at(A_IEN_CLR) ? wmask : '0);
      // A wrap in the same cycle as a clear leaves the bit set.
      ovf <= ((ovf | (wr_at(A_OVF_SET) ? wmask : '0)) & ~(wr_at(A_OVF_CLR) ? wmask : '0)) | wrap;
      if (wr_at(A_CFG) && upper)     run_en <= bus_wdata[0];
      if (wr_at(A_IRQCTL) && !upper) irq_en <= bus_wdata[0];
      for (int n = 0; n < NUM_CTR; n++) begin
        if (bus_wr && sel_hit && reg_idx == 6'(n)) begin
          sel_q[n].code <= bus_wdata[EVID_W-1:0];
          sel_q[n].span <= bus_wdata[SPAN_POS];
        end
        if (bus_wr && mat_hit && reg_idx == 6'(n)) match_q[n] <= bus_wdata[SID_W-1:0];
      end
      irq <= irq_en && |(ovf & ien);
    end
  end

  // ---------------- counter slices ----------------
  for (genvar n = 0; n < NUM_CTR; n++) begin : g_ctr
    evsel_t           eff_sel;
    logic [SID_W-1:0] eff_match;
    logic             wr_lo, wr_hi;

    if (GLOBAL_FILT) begin : g_glob
      assign eff_sel   = '{span: sel_q[0].span, code: sel_q[n].code};
      assign eff_match = match_q[0];
    end else begin : g_local
      assign eff_sel   = sel_q[n];
      assign eff_match = match_q[n];
    end

    assign wr_lo = bus_wr && ctr_hit && (ctr_idx == 6'(n)) && !(WIDE && upper);
    assign wr_hi = bus_wr && ctr_hit && (ctr_idx == 6'(n)) &&  (WIDE && upper);

    ecg_counter #(.CTR_W(CTR_W), .SID_W(SID_W), .LANES(LANES)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .run      (run_en && cen[n]),
      .ev_valid (ev_valid),
      .ev_id    (ev_id),
      .ev_sid   (ev_sid),
      .sel      (eff_sel),
      .match    (eff_match),
      .wr_lo    (wr_lo),
      .wr_hi    (wr_hi),
      .wdata    (bus_wdata),
      .count    (cnt[n]),
      .wrap     (wrap[n])
    );

    // R10
    wrap_sets_ovf_chk: assert property (@(posedge clk) disable iff (rst)
      wrap[n] |=> ovf[n]);
  end

  // ---------------- read path ----------------
  logic [31:0] rmux;

  always_comb begin
    rmux = '0;
    if (ctr_hit) begin
      for (int n = 0; n < NUM_CTR; n++)
        if (ctr_idx == 6'(n)) rmux = half_of(64'(cnt[n]), WIDE && upper);
    end else if (sel_hit) begin
      for (int n = 0; n < NUM_CTR; n++)
        if (reg_idx == 6'(n))
          rmux = 32'(sel_q[n].code) | (32'(sel_q[n].span) << SPAN_POS);
    end else if (mat_hit) begin
      for (int n = 0; n < NUM_CTR; n++)
        if (reg_idx == 6'(n)) rmux = 32'(match_q[n]);
    end else if (aligned) begin
      case (pair)
        A_CEN_SET, A_CEN_CLR: rmux = half_of(64'(cen), upper);
        A_IEN_SET, A_IEN_CLR: rmux = half_of(64'(ien), upper);
        A_OVF_SET, A_OVF_CLR: rmux = half_of(64'(ovf), upper);
        A_CFG:                rmux = upper ? 32'(run_en) : CFG_VAL;
        A_EVM_LO:             rmux = half_of(EV_SUPPORT[63:0], upper);
        A_EVM_HI:             rmux = half_of(EV_SUPPORT[127:64], upper);
        A_IRQCTL:             rmux = upper ? 32'h0 : 32'(irq_en);
        default:              rmux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rmux;
  end

  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(irq_en));

  // R11
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|(ovf & ien)));
endmodule

// File: tb/evt_counter_group_test.sv
`timescale 1ns/1ps
module evt_counter_group_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata_a, rdata_g;
  logic [1:0]  ev_valid = '0;
  logic [31:0] ev_id = '0;
  logic [63:0] ev_sid = '0;
  logic        irq_a, irq_g;
  int          n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  evt_counter_group uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .ev_valid(ev_valid), .ev_id(ev_id),
    .ev_sid(ev_sid), .irq(irq_a));

  evt_counter_group #(.CTR_W(40), .GLOBAL_FILT(1'b1)) uut_g (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_g), .ev_valid(ev_valid), .ev_id(ev_id),
    .ev_sid(ev_sid), .irq(irq_g));

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // One bus/event cycle, then return to idle.
  task automatic cyc(input bit wr, input bit rd, input logic [11:0] a, input logic [31:0] d,
                     input logic [1:0] v, input logic [15:0] id0, input logic [15:0] id1,
                     input logic [31:0] s0, input logic [31:0] s1);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    ev_valid = v; ev_id = {id1, id0}; ev_sid = {s1, s0};
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; ev_valid = '0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    cyc(1, 0, a, d, 2'b00, 0, 0, 0, 0);
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] ga, output logic [31:0] gg);
    cyc(0, 1, a, 0, 2'b00, 0, 0, 0, 0);
    ga = rdata_a; gg = rdata_g;
  endtask

  task automatic ev(input logic [1:0] v, input logic [15:0] id0, input logic [15:0] id1,
                    input logic [31:0] s0, input logic [31:0] s1);
    cyc(0, 0, 12'h0, 0, v, id0, id1, s0, s1);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic t_reset();
    logic [31:0] a, g;
    do_reset();
    chk("R1 irq", {irq_a, irq_g}, 0);
    rd(12'h000, a, g); chk("R1 counter0", a, 0);
    rd(12'hC00, a, g); chk("R1 enable mask", a, 0);
    rd(12'hCC0, a, g); chk("R1 overflow mask", a, 0);
    rd(12'hE04, a, g); chk("R1 run bit", a, 0);
    rd(12'h404, a, g); chk("R1 selector", a, 32'h2000_0000);
    rd(12'hA0C, a, g); chk("R1 match", a, 32'hFFFF_FFFF);
  endtask

  task automatic t_config();
    logic [31:0] a, g;
    do_reset();
    rd(12'hE00, a, g);
    chk("R2 cfg local", a, 32'h0000_1F03);
    chk("R2 cfg global", g, 32'h0080_2703);
    wr(12'hE00, 32'hFFFF_FFFF);
    rd(12'hE00, a, g); chk("R2 cfg read-only", a, 32'h0000_1F03);
    rd(12'hE20, a, g); chk("R2 evmask w0", a, 32'hFF);
    rd(12'hE24, a, g); chk("R2 evmask w1", a, 0);
    rd(12'hE2C, a, g); chk("R2 evmask w3", a, 0);
  endtask

  task automatic t_masks();
    logic [31:0] a, g;
    do_reset();
    wr(12'hC00, 32'hA);
    rd(12'hC00, a, g); chk("R4 enable set", a, 32'hA);
    wr(12'hC20, 32'h2);
    rd(12'hC00, a, g); chk("R4 enable clear", a, 32'h8);
    wr(12'hC00, 32'hF0);
    rd(12'hC20, a, g); chk("R4 high bits ignored", a, 32'h8);
    wr(12'hC04, 32'hF);
    rd(12'hC00, a, g); chk("R4 upper word ignored", a, 32'h8);
    wr(12'hC40, 32'h5);
    rd(12'hC60, a, g); chk("R4 irq enable set", a, 32'h5);
    wr(12'hCC0, 32'h3);
    rd(12'hC80, a, g); chk("R4 overflow set", a, 32'h3);
    wr(12'hC80, 32'h1);
    rd(12'hCC0, a, g); chk("R4 overflow clear", a, 32'h2);
  endtask

  task automatic t_count();
    logic [31:0] a, g;
    do_reset();
    wr(12'h400, 32'h2000_0001);
    wr(12'hC00, 32'h1);
    ev(2'b01, 1, 0, 7, 0);
    rd(12'h000, a, g); chk("R3 no run no count", a, 0);
    wr(12'hE04, 32'h1);
    ev(2'b11, 1, 1, 7, 9);
    rd(12'h000, a, g); chk("R3 two lanes", a, 2);
    ev(2'b01, 2, 0, 7, 0);
    rd(12'h000, a, g); chk("R3 wrong code", a, 2);
    ev(2'b10, 0, 1, 0, 3);
    rd(12'h000, a, g); chk("R3 lane1", a, 3);
    wr(12'hC20, 32'h1);
    ev(2'b11, 1, 1, 0, 0);
    rd(12'h000, a, g); chk("R3 disabled", a, 3);
  endtask

  task automatic t_write();
    logic [31:0] a, g;
    do_reset();
    wr(12'hC00, 32'hF);
    wr(12'hE04, 32'h1);
    cyc(1, 0, 12'h000, 32'h1234, 2'b01, 0, 0, 0, 0);
    rd(12'h000, a, g); chk("R5 write wins", a, 32'h1234);
    ev(2'b01, 0, 0, 0, 0);
    rd(12'h000, a, g); chk("R5 counts after load", a, 32'h1235);
    wr(12'hC20, 32'hF);
    wr(12'h00C, 32'h1FF);
    rd(12'h00C, a, g);
    chk("R5 narrow stride", a, 32'h1FF);
    chk("R5 wide upper word", g, 32'hFF);
    wr(12'h008, 32'hAA);
    rd(12'h008, a, g); chk("R5 wide lower word", g, 32'hAA);
  endtask

  task automatic t_selector();
    logic [31:0] a, g;
    do_reset();
    wr(12'h408, 32'hFFFF_FFFF);
    rd(12'h408, a, g); chk("R6 selector fields", a, 32'h2000_FFFF);
    wr(12'h408, 32'h0000_0005);
    rd(12'h408, a, g); chk("R6 span cleared", a, 32'h0000_0005);
  endtask

  task automatic t_exact();
    logic [31:0] a, g;
    do_reset();
    wr(12'h400, 32'h1);
    wr(12'hA00, 32'h42);
    wr(12'hC00, 32'h1);
    wr(12'hE04, 32'h1);
    ev(2'b01, 1, 0, 32'h42, 0);
    rd(12'h000, a, g); chk("R7 exact hit", a, 1);
    ev(2'b11, 1, 1, 32'h43, 32'h40);
    rd(12'h000, a, g); chk("R7 exact miss", a, 1);
  endtask

  task automatic t_span();
    logic [31:0] a, g;
    do_reset();
    wr(12'h400, 32'h2000_0001);
    wr(12'hA00, 32'h42);
    wr(12'hC00, 32'h1);
    wr(12'hE04, 32'h1);
    ev(2'b11, 1, 1, 32'h42, 32'h43);
    rd(12'h000, a, g); chk("R8 span pair", a, 2);
    ev(2'b01, 1, 0, 32'h44, 0);
    rd(12'h000, a, g); chk("R8 span outside", a, 2);
    wr(12'hA00, 32'h45);
    ev(2'b11, 1, 1, 32'h47, 32'h48);
    rd(12'h000, a, g); chk("R8 two ignored bits", a, 3);
  endtask

  task automatic t_global();
    logic [31:0] a, g;
    do_reset();
    wr(12'h400, 32'h0000_0001);
    wr(12'h404, 32'h2000_0001);
    wr(12'hA00, 32'h10);
    wr(12'hC00, 32'h3);
    wr(12'hE04, 32'h1);
    ev(2'b01, 1, 0, 32'h20, 0);
    rd(12'h004, a, g); chk("R9 local counter1 counts", a, 1);
    rd(12'h008, a, g); chk("R9 global counter1 blocked", g, 0);
    ev(2'b01, 1, 0, 32'h10, 0);
    rd(12'h008, a, g); chk("R9 global counter1 passes", g, 1);
  endtask

  task automatic t_overflow();
    logic [31:0] a, g;
    do_reset();
    wr(12'h000, 32'hFFFF_FFFF);
    wr(12'hC00, 32'h1);
    wr(12'hC40, 32'h1);
    wr(12'hE04, 32'h1);
    ev(2'b01, 0, 0, 0, 0);
    @(negedge clk);
    chk("R11 masked by control", irq_a, 0);
    rd(12'h000, a, g); chk("R10 wrapped value", a, 0);
    rd(12'hCC0, a, g); chk("R10 overflow set", a, 1);
    wr(12'hE50, 32'h1);
    @(negedge clk);
    chk("R11 irq raised", irq_a, 1);
    wr(12'hC80, 32'h1);
    @(negedge clk);
    chk("R11 irq dropped", irq_a, 0);
    wr(12'h000, 32'hFFFF_FFFF);
    cyc(1, 0, 12'hC80, 32'h1, 2'b01, 0, 0, 0, 0);
    rd(12'hC80, a, g); chk("R10 wrap beats clear", a, 1);
  endtask

  task automatic t_unmapped();
    logic [31:0] a, g;
    do_reset();
    wr(12'h800, 32'hFFFF);
    rd(12'h800, a, g); chk("R12 hole reads zero", a, 0);
    rd(12'h010, a, g); chk("R12 counter beyond range", a, 0);
    wr(12'hC01, 32'hF);
    rd(12'hC00, a, g); chk("R12 unaligned write ignored", a, 0);
    wr(12'h400, 32'h7);
    rd(12'h401, a, g); chk("R12 unaligned read zero", a, 0);
  endtask

  initial begin
    t_reset();
    t_config();
    t_masks();
    t_count();
    t_write();
    t_selector();
    t_exact();
    t_span();
    t_global();
    t_overflow();
    t_unmapped();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #800000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule